// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block turns up to 32 already-synchronized input pin levels into interrupt requests. Every pin has its own 4-bit sense field. The field selects what the pin detects: a rising edge, a falling edge, either edge, a high level or a low level. Detected events are held in a per-pin pending register, the raw status. An enable mask turns that into the masked status. The masked status is reduced onto two request lines, one for the lower half of the pins and one for the upper half.

Software controls the block through a word-wide register bus. A read/write accept register gates detection pin by pin. The intended sequence for changing a pin's sense mode is: turn its accept bit off, rewrite the field, clear any stale pending bit, then turn accept back on. The enable mask has no plain write port. It has a set port and a clear port, and both act only on the bits written as one, so two agents can change different pins without a read-modify-write. Pending bits are cleared by writing ones to a dedicated clear port.

The sense word at offset 0x20 + 4*k holds the fields of pins 8k to 8k+7. Pin n sits at bits [4*(n%8)+3 : 4*(n%8)] of word n/8. Detection depends only on the low three bits of a field. Bit 3 is stored and read back but changes nothing.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the accept, mask, raw and masked status and all four sense words read as zero, and both request lines are low.
- R2: A sense word written at 0x20, 0x24, 0x28 or 0x2C reads back unchanged. The field of pin n is bits [4*(n%8)+3 : 4*(n%8)] of the word at 0x20 + 4*(n/8).
- R3: Sense codes 0 (rising), 1 (falling) and 4 (either edge) set the pin's pending bit one clock after the matching change of its level. The bit then stays set until it is cleared, even after the level changes back.
- R4: Sense codes 2 (high) and 3 (low) set the pending bit on every clock edge at which the level is present, so a clear has no lasting effect while the level remains. Once the level is gone, a clear removes the bit.
- R5: Codes 5, 6 and 7 detect nothing. Field bit 3 has no effect on detection: code 8 behaves like code 0.
- R6: The accept register at 0x00 is read/write. A pin whose accept bit is 0 never gains a pending bit, but its level is still tracked, so turning accept on does not create a false edge.
- R7: Writing ones to 0x04 enables those pins and writing ones to 0x08 disables them. Zero bits in either write have no effect. The mask reads back at 0x0C.
- R8: The raw status at 0x10 shows pending bits whatever the mask. The masked status at 0x14 is the raw status ANDed with the mask.
- R9: Writing ones to 0x18 clears those pending bits at the next clock. If a new event on a pin arrives at the same clock edge as the clear of that pin, the event wins and the bit stays pending.
- R10: irqReq[0] is the OR of the masked status of pins 0 to 15, and irqReq[1] is the OR for pins 16 to 31. Both follow a mask change at the edge that writes it.
- R11: busRdData follows busAddr in the same cycle. An access whose address bits [1:0] are not zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pinLevel | input | 32 | Synchronized pin levels |
| irqReq | output | 2 | Request lines: [0] for pins 0-15, [1] for pins 16-31 |

## Verification
The hardest case to reach from the ports is a pin edge that lands at the same clock edge as a software clear of that pin. The bench first makes the bit pending, then returns the pin to its idle level. In a single negedge it then drives both the new edge and the clear write, so both are seen at the same rising edge. Level modes are harder to observe because they re-arm on every clock edge. The bench therefore clears them while the level is still held, and checks that the bit is still set one cycle later.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  localparam int FIELD_W = 4;

  // word indices (byte offset / 4) of the register map
  localparam int IDX_ACCEPT = 0;
  localparam int IDX_EN_SET = 1;
  localparam int IDX_EN_CLR = 2;
  localparam int IDX_EN_VIEW = 3;
  localparam int IDX_RAW = 4;
  localparam int IDX_MASKED = 5;
  localparam int IDX_CLEAR = 6;
  localparam int IDX_SENSE0 = 8;

  typedef enum logic [2:0] {
    MODE_RISE = 3'd0,
    MODE_FALL = 3'd1,
    MODE_HIGH = 3'd2,
    MODE_LOW  = 3'd3,
    MODE_BOTH = 3'd4
  } senseMode_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACCEPT,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED,
    SEL_SENSE
  } rdSel_t;

  typedef struct packed {
    logic       acceptWr;
    logic       enSetWr;
    logic       enClrWr;
    logic       pendClrWr;
    logic       senseWr;
    logic [2:0] senseIdx;
    rdSel_t     rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import gpio_sense_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SENSE_WORDS = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  localparam int WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] wordIdx;
  logic [WIDX_W-1:0] senseOff;
  logic              inSense;
  logic              wrOk;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign wordIdx  = busAddr[ADDR_W-1:2];
  assign senseOff = wordIdx - WIDX_W'(IDX_SENSE0);
  assign inSense  = (wordIdx >= WIDX_W'(IDX_SENSE0)) &&
                    (wordIdx <  WIDX_W'(IDX_SENSE0 + SENSE_WORDS));
  assign wrOk     = busWrEn && aligned;

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = SEL_NONE;
    strobe.senseIdx  = senseOff[2:0];
    strobe.acceptWr  = wrOk && (wordIdx == WIDX_W'(IDX_ACCEPT));
    strobe.enSetWr   = wrOk && (wordIdx == WIDX_W'(IDX_EN_SET));
    strobe.enClrWr   = wrOk && (wordIdx == WIDX_W'(IDX_EN_CLR));
    strobe.pendClrWr = wrOk && (wordIdx == WIDX_W'(IDX_CLEAR));
    strobe.senseWr   = wrOk && inSense;
    if (aligned) begin
      if (inSense) begin
        strobe.rdSel = SEL_SENSE;
      end else begin
        case (wordIdx)
          WIDX_W'(IDX_ACCEPT):  strobe.rdSel = SEL_ACCEPT;
          WIDX_W'(IDX_EN_VIEW): strobe.rdSel = SEL_MASK;
          WIDX_W'(IDX_RAW):     strobe.rdSel = SEL_RAW;
          WIDX_W'(IDX_MASKED):  strobe.rdSel = SEL_MASKED;
          default:              strobe.rdSel = SEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_sense_datapath.sv
module irq_sense_datapath
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SENSE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinLevel,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] rawPend,
  output logic [NUM_PINS-1:0] enMask,
  output logic [NUM_PINS-1:0] acceptBits,
  output logic [1:0]          irqReq
);

  localparam int FPW     = DATA_W / FIELD_W;
  localparam int LO_PINS = NUM_PINS / 2;

  logic [DATA_W-1:0]   senseWord [SENSE_WORDS];
  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] clrBits;
  logic [NUM_PINS-1:0] maskedPend;
  logic [NUM_PINS-1:0] wrPins;

  assign wrPins  = wrData[NUM_PINS-1:0];
  assign clrBits = strobe.pendClrWr ? wrPins : '0;

  // per-pin event detection
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [2:0] code;
    logic       cur;
    logic       old;
    assign code = senseWord[i / FPW][(i % FPW) * FIELD_W +: 3];
    assign cur  = pinLevel[i];
    assign old  = prevLevel[i];
    always_comb begin
      case (senseMode_t'(code))
        MODE_RISE: hitVec[i] = acceptBits[i] & cur & ~old;
        MODE_FALL: hitVec[i] = acceptBits[i] & ~cur & old;
        MODE_HIGH: hitVec[i] = acceptBits[i] & cur;
        MODE_LOW:  hitVec[i] = acceptBits[i] & ~cur;
        MODE_BOTH: hitVec[i] = acceptBits[i] & (cur ^ old);
        default:   hitVec[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLevel  <= '0;
      rawPend    <= '0;
      enMask     <= '0;
      acceptBits <= '0;
    end else begin
      prevLevel <= pinLevel;
      rawPend   <= (rawPend & ~clrBits) | hitVec;
      if (strobe.acceptWr) acceptBits <= wrPins;
      if (strobe.enSetWr)  enMask <= enMask | wrPins;
      else if (strobe.enClrWr) enMask <= enMask & ~wrPins;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < SENSE_WORDS; w++) begin
      if (rst) begin
        senseWord[w] <= '0;
      end else if (strobe.senseWr && (strobe.senseIdx == 3'(w))) begin
        senseWord[w] <= wrData;
      end
    end
  end

  assign maskedPend = rawPend & enMask;
  assign irqReq[0]  = |maskedPend[LO_PINS-1:0];
  assign irqReq[1]  = |maskedPend[NUM_PINS-1:LO_PINS];

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_ACCEPT: rdData = DATA_W'(acceptBits);
      SEL_MASK:   rdData = DATA_W'(enMask);
      SEL_RAW:    rdData = DATA_W'(rawPend);
      SEL_MASKED: rdData = DATA_W'(maskedPend);
      SEL_SENSE: begin
        for (int w = 0; w < SENSE_WORDS; w++) begin
          if (strobe.senseIdx == 3'(w)) rdData = senseWord[w];
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] pinLevel,
  output logic [1:0]          irqReq
);

  localparam int FPW         = DATA_W / FIELD_W;
  localparam int SENSE_WORDS = (NUM_PINS + FPW - 1) / FPW;

  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] rawPend;
  logic [NUM_PINS-1:0] enMask;
  logic [NUM_PINS-1:0] acceptBits;

  irq_sense_ctrl #(
    .ADDR_W      (ADDR_W),
    .SENSE_WORDS (SENSE_WORDS)
  ) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  irq_sense_datapath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SENSE_WORDS (SENSE_WORDS)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wrData     (busWrData),
    .pinLevel   (pinLevel),
    .rdData     (busRdData),
    .rawPend    (rawPend),
    .enMask     (enMask),
    .acceptBits (acceptBits),
    .irqReq     (irqReq)
  );

endmodule

// File: rtl/irq_sense_checker.sv
module irq_sense_checker
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic [1:0]          irqReq,
  input logic [NUM_PINS-1:0] rawPend,
  input logic [NUM_PINS-1:0] enMask,
  input logic [NUM_PINS-1:0] acceptBits
);

  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(IDX_EN_CLR * 4);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(IDX_CLEAR * 4);

  // R1: nothing requested right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irqReq == 2'b00));

  // R7: disabling every pin drops the mask and both lines
  a_r7_disable_all: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == A_EN_CLR && busWrData == '1)
      |=> (enMask == '0 && irqReq == 2'b00));

  // R6: with no pin accepted no new pending bit appears
  a_r6_no_accept_no_set: assert property (@(posedge clk) disable iff (rst)
    (acceptBits == '0) |=> ((rawPend & ~$past(rawPend)) == '0));

  // R9: a clear with no accepted pin removes the written bits
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == A_CLEAR && acceptBits == '0)
      |=> ((rawPend & $past(busWrData[NUM_PINS-1:0])) == '0));

  // R10: a request line needs an enabled pending pin
  a_r10_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    (irqReq != 2'b00) |-> (enMask != '0 && rawPend != '0));

endmodule

bind gpio_irq_sense irq_sense_checker #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .irqReq     (irqReq),
  .rawPend    (rawPend),
  .enMask     (enMask),
  .acceptBits (acceptBits)
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinLevel = '0;
  logic [1:0]  irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  logic benchDone = 1'b0;

  typedef struct {
    int          kind;   // 0 = register read, 1 = request lines
    logic [31:0] msk;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_irq_sense u_gpio_irq_sense (
    .clk       (clk),
    .rst       (rst),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinLevel  (pinLevel),
    .irqReq    (irqReq)
  );

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = (it.kind == 0) ? (busRdData & it.msk) : {30'b0, irqReq};
        testsRun++;
        if (act !== it.exp) begin
          testsFailed++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic wrWithPins(input logic [7:0] a, input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; pinLevel = p;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic setPins(input logic [31:0] p);
    @(negedge clk);
    pinLevel = p;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] m, input logic [31:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = a;
    #1;
    it.kind = 0; it.msk = m; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
  endtask

  task automatic chkIrq(input logic [1:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    #1;
    it.kind = 1; it.msk = '1; it.exp = {30'b0, e}; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!benchDone) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] pins;
    pins = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(8'h00, '1, 32'h0, "R1 accept");
    rd(8'h0C, '1, 32'h0, "R1 mask");
    rd(8'h10, '1, 32'h0, "R1 raw");
    rd(8'h14, '1, 32'h0, "R1 masked");
    for (int k = 0; k < 4; k++) rd(8'(8'h20 + 4 * k), '1, 32'h0, "R1 sense");
    chkIrq(2'b00, "R1 irq");

    // R2 sense layout: pin0 rise,1 fall,2 high,3 low,4 both,5 code5,6 code8,7 code7
    wr(8'h20, 32'h7854_3210);
    wr(8'h24, 32'h0000_0030);   // pin9 low level
    wr(8'h2C, 32'hA5A5_A5A5);
    rd(8'h20, '1, 32'h7854_3210, "R2 word0");
    rd(8'h24, '1, 32'h0000_0030, "R2 word1");
    rd(8'h2C, '1, 32'hA5A5_A5A5, "R2 word3");
    rd(8'h28, '1, 32'h0, "R2 word2");

    // R11 misaligned write is dropped, misaligned read is zero
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, '1, 32'h0, "R11 misaligned write");
    rd(8'h21, '1, 32'h0, "R11 misaligned read");

    // R3 rising edge, R6 pin1 not accepted
    wr(8'h00, 32'h1);
    pins = 32'h3; setPins(pins);
    rd(8'h10, 32'h3, 32'h1, "R3 rise / R6 gated");
    chkIrq(2'b00, "R8 masked off");
    rd(8'h14, '1, 32'h0, "R8 masked status zero");

    // R7 / R10 enable
    wr(8'h04, 32'h1);
    rd(8'h0C, '1, 32'h1, "R7 enable set");
    chkIrq(2'b01, "R10 low line");
    rd(8'h14, '1, 32'h1, "R8 masked status");

    pins = 32'h2; setPins(pins);
    rd(8'h10, 32'h1, 32'h1, "R3 edge sticky");
    wr(8'h18, 32'h1);
    rd(8'h10, 32'h1, 32'h0, "R9 clear");
    chkIrq(2'b00, "R9 irq drops");

    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    rd(8'h0C, '1, 32'h1, "R7 zero bits no effect");

    // R4 level modes, R6 no false edge on accept
    wr(8'h00, 32'hFFFF_FFFF);
    @(posedge clk);
    rd(8'h10, '1, 32'h0000_0208, "R4 low levels / R6 no false edge");
    wr(8'h18, 32'h0000_0208);
    rd(8'h10, 32'h208, 32'h208, "R4 level re-arms");
    pins = pins | 32'h4; setPins(pins);
    rd(8'h10, 32'h4, 32'h4, "R4 high level");
    pins = pins | 32'h8; setPins(pins);
    wr(8'h18, 32'h8);
    rd(8'h10, 32'h8, 32'h0, "R4 level gone clears");

    // R3 falling and both edges
    pins = pins & ~32'h2; setPins(pins);
    rd(8'h10, 32'h2, 32'h2, "R3 falling");
    pins = pins | 32'h10; setPins(pins);
    rd(8'h10, 32'h10, 32'h10, "R3 both rise");
    wr(8'h18, 32'h10);
    rd(8'h10, 32'h10, 32'h0, "R9 clear both");
    pins = pins & ~32'h10; setPins(pins);
    rd(8'h10, 32'h10, 32'h10, "R3 both fall");

    // R5 reserved codes and bit 3
    pins = pins | 32'hA0; setPins(pins);
    rd(8'h10, 32'hA0, 32'h0, "R5 codes 5/7 rise");
    pins = pins & ~32'hA0; setPins(pins);
    rd(8'h10, 32'hA0, 32'h0, "R5 codes 5/7 fall");
    pins = pins | 32'h40; setPins(pins);
    rd(8'h10, 32'h40, 32'h40, "R5 bit3 ignored");

    // R10 upper line
    pins = pins | 32'h0002_0000; setPins(pins);
    rd(8'h10, 32'h0002_0000, 32'h0002_0000, "R3 pin17 rise");
    chkIrq(2'b00, "R10 upper masked");
    wr(8'h04, 32'h0002_0000);
    chkIrq(2'b10, "R10 upper line");
    rd(8'h14, '1, 32'h0002_0000, "R8 masked upper");
    wr(8'h08, 32'hFFFF_FFFF);
    chkIrq(2'b00, "R7 disable all irq");
    rd(8'h0C, '1, 32'h0, "R7 disable all");

    // R9 collision: new edge at the clearing edge wins
    pins = pins | 32'h0001_0000; setPins(pins);
    rd(8'h10, 32'h0001_0000, 32'h0001_0000, "R3 pin16 rise");
    pins = pins & ~32'h0001_0000; setPins(pins);
    pins = pins | 32'h0001_0000;
    wrWithPins(8'h18, 32'h0001_0000, pins);
    rd(8'h10, 32'h0001_0000, 32'h0001_0000, "R9 edge wins");
    wr(8'h18, 32'h0001_0000);
    rd(8'h10, 32'h0001_0000, 32'h0, "R9 clear after collision");

    // R6 accept off stops a held level
    wr(8'h00, 32'hFFFF_FFFB);
    wr(8'h18, 32'h4);
    @(posedge clk);
    rd(8'h10, 32'h4, 32'h0, "R6 accept off");
    rd(8'h00, '1, 32'hFFFF_FFFB, "R6 accept readback");

    @(negedge clk);
    benchDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule